// File: doc/BRIEF.md
# Scheduler Command Handshake Interface

This block sits between a thread-manager unit and a hardware scheduler on a dedicated point-to-point link. The manager presents an opcode, a data word, the identifier of the thread now running on the CPU, and a request strobe. The block answers with a busy flag, a return-data word, and a pre-computed next-thread identifier with its valid flag. It decodes four commands: enqueue, dequeue, is-queued and is-empty. It executes each one against a small ready-set stub, in which each thread is one bit.

The next-thread decision is always prepared ahead of use. The lowest-numbered queued thread has the highest priority. A context switch reads the ready identifier and then issues a dequeue, which removes exactly that thread. Any enqueue, and any dequeue that is carried out, marks the decision stale. The valid flag drops for one cycle, and the decision is then recomputed while the manager carries on with its own work.

The command sequencer has two states, S_IDLE and S_EXEC. The transition T_ACCEPT (S_IDLE to S_EXEC) is taken on a clock edge where `req` is 1 and `busy` is 0; the sequencer then latches the opcode and thread identifier. The transition T_DONE (S_EXEC to S_IDLE) is taken on the next edge. On that edge the command is executed, the return data is registered and busy falls. `busy` is 1 exactly while the sequencer is in S_EXEC.

Top module: `sched_cmd_if`

## Requirements
- R1: While reset is active, and after it is released until the first command completes, `busy`, `next_valid`, `next_id` and `ret_data` are all 0.
- R2: A request is accepted on a rising edge where `req`=1 and `busy`=0. `busy` is then 1 for exactly the following cycle. A request level, opcode or data presented while `busy`=1 has no effect.
- R3: `ret_data` changes only on the edge where `busy` falls, and it holds its value from then until the next accepted command completes.
- R4: Enqueue (op 2'b00) adds the thread numbered by the low TID_W bits of `data` to the ready set. Enqueuing a thread that is already queued leaves the set unchanged. `ret_data` bit 0 is 1 exactly when the new thread number is lower than `cur_id` (a preemption hint), and every other bit is 0.
- R5: Dequeue (op 2'b01) with `next_valid`=1 removes the thread `next_id` from the set and returns that identifier, zero-extended, on `ret_data`.
- R6: Dequeue with `next_valid`=0 returns all ones on `ret_data`. It leaves the ready set and `next_valid` unchanged.
- R7: Is-queued (op 2'b10) returns 1 if the thread numbered by the low TID_W bits of `data` is in the set, and 0 otherwise. It leaves the set and `next_valid` unchanged.
- R8: Is-empty (op 2'b11) returns 1 if the set is empty and 0 otherwise. It leaves the set and `next_valid` unchanged.
- R9: After an enqueue or a carried-out dequeue, `next_valid` is 0 in the cycle where `busy` falls. One cycle later `next_valid` equals "set not empty", and when it is 1, `next_id` is the lowest-numbered queued thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Command request strobe |
| op | input | 2 | Command opcode |
| data | input | DATA_W | Command parameter (thread number in low bits) |
| cur_id | input | TID_W | Thread now running on the CPU |
| busy | output | 1 | Command in progress; no request accepted |
| ret_data | output | DATA_W | Result of the last completed command |
| next_id | output | TID_W | Pre-computed next thread to run |
| next_valid | output | 1 | next_id holds a current decision |

## Verification
The bench builds the block with TID_W=4 and DATA_W=8, which gives sixteen threads and an error code well clear of any identifier. With so few threads, random commands often reach a full set, an empty set, duplicate enqueues, dequeues of the last thread, and rejected dequeues. The directed cases cover the reset state, a request held while busy with a changed opcode, and preemption hints on both sides of `cur_id`.

// File: rtl/sched_cmd_pkg.sv
package sched_cmd_pkg;

    typedef enum logic [1:0] {
        OP_ENQ = 2'b00,
        OP_DEQ = 2'b01,
        OP_ISQ = 2'b10,
        OP_EMP = 2'b11
    } sched_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EXEC = 1'b1
    } cmd_state_e;

endpackage

// File: rtl/sched_ready_set.sv
module sched_ready_set #(
    parameter int TID_W = 4,
    localparam int NTHR = 1 << TID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [TID_W-1:0] set_id,
    input  logic             clr_en,
    input  logic [TID_W-1:0] clr_id,
    input  logic [TID_W-1:0] q_id,
    output logic             q_hit,
    output logic             q_any,
    output logic [NTHR-1:0]  bits
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            if (set_en) bits[set_id] <= 1'b1;
            if (clr_en) bits[clr_id] <= 1'b0;
        end
    end

    assign q_hit = bits[q_id];
    assign q_any = |bits;

    // R5: only a queued thread is ever removed
    a_r5_clear_member: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> bits[clr_id]);

endmodule

// File: rtl/sched_next_pick.sv
module sched_next_pick #(
    parameter int TID_W = 4,
    localparam int NTHR = 1 << TID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTHR-1:0]  bits,
    input  logic             stale,
    output logic             next_valid,
    output logic [TID_W-1:0] next_id
);

    logic             pending;
    logic [TID_W-1:0] lowest;

    always_comb begin
        lowest = '0;
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (bits[i]) lowest = TID_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_valid <= 1'b0;
            next_id    <= '0;
            pending    <= 1'b1;
        end else if (stale) begin
            next_valid <= 1'b0;
            pending    <= 1'b1;
        end else if (pending) begin
            next_valid <= |bits;
            next_id    <= lowest;
            pending    <= 1'b0;
        end
    end

    // R9: a stale decision is never offered on the edge that marks it
    a_r9_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
        stale |=> !next_valid);

endmodule

// File: rtl/sched_cmd_fsm.sv
module sched_cmd_fsm
    import sched_cmd_pkg::*;
#(
    parameter int TID_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] data,
    input  logic [TID_W-1:0]  cur_id,
    input  logic              q_hit,
    input  logic              q_any,
    input  logic              next_valid,
    input  logic [TID_W-1:0]  next_id,
    output logic              busy,
    output logic [DATA_W-1:0] ret_data,
    output logic              set_en,
    output logic              clr_en,
    output logic [TID_W-1:0]  tid_q,
    output logic              stale
);

    localparam logic [DATA_W-1:0] RET_ERR = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] RET_ONE = DATA_W'(1);

    cmd_state_e state, state_nx;
    sched_op_e  op_q;
    logic       exec;
    logic       accept;

    assign accept = req && (state == S_IDLE);
    assign exec   = (state == S_EXEC);
    assign busy   = exec;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_EXEC;   // T_ACCEPT
            S_EXEC: state_nx = S_IDLE;               // T_DONE
        endcase
    end

    assign set_en = exec && (op_q == OP_ENQ);
    assign clr_en = exec && (op_q == OP_DEQ) && next_valid;
    assign stale  = set_en || clr_en;

    // output and command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ENQ;
            tid_q    <= '0;
            ret_data <= '0;
        end else begin
            if (accept) begin
                op_q  <= sched_op_e'(op);
                tid_q <= data[TID_W-1:0];
            end
            if (exec) begin
                unique case (op_q)
                    OP_ENQ: ret_data <= (tid_q < cur_id) ? RET_ONE : '0;
                    OP_DEQ: ret_data <= next_valid ? DATA_W'(next_id) : RET_ERR;
                    OP_ISQ: ret_data <= q_hit ? RET_ONE : '0;
                    OP_EMP: ret_data <= q_any ? '0 : RET_ONE;
                endcase
            end
        end
    end

    // R2: a request seen while idle makes busy rise on the next cycle
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R2: busy lasts exactly one cycle
    a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R3: return data moves only on the completing edge
    a_r3_ret_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ret_data));

endmodule

// File: rtl/sched_cmd_if.sv
module sched_cmd_if #(
    parameter int TID_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] data,
    input  logic [TID_W-1:0]  cur_id,
    output logic              busy,
    output logic [DATA_W-1:0] ret_data,
    output logic [TID_W-1:0]  next_id,
    output logic              next_valid
);

    localparam int NTHR = 1 << TID_W;

    logic             q_hit, q_any, set_en, clr_en, stale;
    logic [TID_W-1:0] tid_q;
    logic [NTHR-1:0]  bits;

    sched_cmd_fsm #(.TID_W(TID_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .data(data),
        .cur_id(cur_id), .q_hit(q_hit), .q_any(q_any),
        .next_valid(next_valid), .next_id(next_id), .busy(busy),
        .ret_data(ret_data), .set_en(set_en), .clr_en(clr_en),
        .tid_q(tid_q), .stale(stale)
    );

    sched_ready_set #(.TID_W(TID_W)) u_set (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_id(tid_q),
        .clr_en(clr_en), .clr_id(next_id), .q_id(tid_q),
        .q_hit(q_hit), .q_any(q_any), .bits(bits)
    );

    sched_next_pick #(.TID_W(TID_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .bits(bits), .stale(stale),
        .next_valid(next_valid), .next_id(next_id)
    );

    // R9: an offered decision always names a queued thread
    a_r9_valid_member: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid |-> bits[next_id]);

    // R6: a rejected dequeue leaves the ready set untouched
    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !next_valid && !set_en) |=> $stable(bits));

endmodule

// File: tb/sim_sched_cmd_if.sv
module sim_sched_cmd_if;

    localparam int TID_W  = 4;
    localparam int DATA_W = 8;
    localparam int NTHR   = 1 << TID_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [DATA_W-1:0] data = '0;
    logic [TID_W-1:0]  cur_id = '0;
    logic              busy;
    logic [DATA_W-1:0] ret_data;
    logic [TID_W-1:0]  next_id;
    logic              next_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [NTHR-1:0] model = '0;

    sched_cmd_if #(.TID_W(TID_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .data(data),
        .cur_id(cur_id), .busy(busy), .ret_data(ret_data),
        .next_id(next_id), .next_valid(next_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [TID_W-1:0] low_of(input logic [NTHR-1:0] m);
        logic [TID_W-1:0] r = '0;
        for (int i = NTHR - 1; i >= 0; i--) if (m[i]) r = TID_W'(i);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] exp_ret(input logic [1:0] o,
            input logic [TID_W-1:0] id, input logic [TID_W-1:0] cur,
            input logic [NTHR-1:0] m);
        case (o)
            2'b00: return (id < cur) ? 8'd1 : 8'd0;
            2'b01: return (m != 0) ? DATA_W'(low_of(m)) : 8'hFF;
            2'b10: return m[id] ? 8'd1 : 8'd0;
            default: return (m == 0) ? 8'd1 : 8'd0;
        endcase
    endfunction

    task automatic run_op(input logic [1:0] o, input logic [TID_W-1:0] id,
                          input logic [TID_W-1:0] cur, input bit hold_busy);
        logic [DATA_W-1:0] er;
        bit st;
        bit prev_v;
        @(negedge clk);
        req = 1'b1; op = o; data = DATA_W'(id); cur_id = cur;
        @(negedge clk);
        chk("R2 busy high after accept", busy, 1);
        if (hold_busy) begin
            op = 2'b00; data = DATA_W'(NTHR - 1);
        end else begin
            req = 1'b0;
        end
        er = exp_ret(o, id, cur, model);
        prev_v = (model != 0);
        st = (o == 2'b00) || (o == 2'b01 && model != 0);
        if (o == 2'b00) model[id] = 1'b1;
        if (o == 2'b01 && model != 0) model[low_of(model)] = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk("R2 busy single cycle", busy, 0);
        case (o)
            2'b00: chk("R4 enqueue ret", ret_data, er);
            2'b01: chk(er == 8'hFF ? "R6 reject ret" : "R5 dequeue ret", ret_data, er);
            2'b10: chk("R7 isq ret", ret_data, er);
            default: chk("R8 empty ret", ret_data, er);
        endcase
        if (st) chk("R9 valid drops", next_valid, 0);
        else    chk("R7 R8 R6 valid kept", next_valid, prev_v);
        @(negedge clk);
        chk("R9 valid recomputed", next_valid, model != 0);
        if (model != 0) chk("R9 next id lowest", next_id, low_of(model));
        chk("R3 ret held", ret_data, er);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", next_valid, 0);
        chk("R1 ret in reset", ret_data, 0);
        chk("R1 next id in reset", next_id, 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 valid after reset", next_valid, 0);
        chk("R1 busy after reset", busy, 0);

        // rejected dequeue on empty set, then confirm still empty
        run_op(2'b01, 0, 0, 0);
        run_op(2'b11, 0, 0, 0);
        // preemption hint both sides of cur_id
        run_op(2'b00, 4'd3, 4'd5, 0);
        run_op(2'b00, 4'd9, 4'd5, 0);
        run_op(2'b00, 4'd5, 4'd5, 0);
        // duplicate enqueue
        run_op(2'b00, 4'd3, 4'd0, 0);
        // changed opcode while busy must be ignored (R2)
        run_op(2'b10, 4'd9, 4'd0, 1);
        run_op(2'b10, 4'(NTHR - 1), 4'd0, 0);
        chk("R2 held request ignored", model[NTHR-1], 0);
        // drain
        repeat (4) run_op(2'b01, 0, 0, 0);
        run_op(2'b11, 0, 0, 0);

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [1:0] o;
            int pick = $urandom_range(0, 9);
            o = (pick < 4) ? 2'b00 : (pick < 7) ? 2'b01 : (pick < 9) ? 2'b10 : 2'b11;
            run_op(o, TID_W'($urandom), TID_W'($urandom), 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule